// File: doc/BRIEF.md
# Serial-Loaded Dual-Latch Output Driver

This block is the logic core of a multi-channel output driver that is loaded serially. A serial bit stream is shifted in on the rising edges of a slow shift clock. The last stage is passed on to a cascade pin, so several drivers can be chained from one serial line. On command, the shifted word is copied into one of two parallel latches. One latch holds the data pattern. The other holds a per-channel polarity pattern.

Each parallel output is the XNOR of its polarity bit with either its data bit or a forced one. The blanking input picks which. With blanking active, every output therefore rests at its polarity level. A polarity bit of one gives a non-inverted channel.

The design runs on a system clock. The shift clock and serial data pass through a synchronizer, and each rising shift-clock edge becomes a one-cycle advance pulse. The latch-enable, select and blank inputs are taken as synchronous to the system clock. The pull-ups that hold these three inputs high when undriven sit at the pads and are not part of this logic.

Top module: `sdl_driver`

## Requirements
- R1: Each rising edge of `shift_clk` moves the shift register one place: stage i+1 takes stage i, and stage 0 takes `shift_din`. Shift stage i feeds channel i (`drive_out[i]`). After CHANNELS shifts, the first bit shifted in sits in stage CHANNELS-1.
- R2: `cascade_out` is one extra stage behind the last shift stage. It takes the old value of stage CHANNELS-1 on every shift. A bit therefore reaches `cascade_out` one shift after it reaches the last stage.
- R3: Shifting does not depend on `latch_en`, `latch_sel` or `blank_n`. Toggling them during a shift leaves the shifted word unchanged.
- R4: While `latch_en` is low, neither latch changes, whatever the shift register does.
- R5: In a cycle where `latch_en` is high and `latch_sel` is 1, the shift register is copied into the data latch. The polarity latch is left unchanged.
- R6: In a cycle where `latch_en` is high and `latch_sel` is 0, the shift register is copied into the polarity latch. The data latch is left unchanged.
- R7: While `blank_n` is 0, `drive_out` equals the polarity latch.
- R8: While `blank_n` is 1, `drive_out[i]` equals XNOR of data bit i and polarity bit i.
- R9: Asynchronous reset (`rst_n` low) sets the shift register, the data latch and `cascade_out` to 0, and the polarity latch to all ones. After reset, `drive_out` is all zeros with `blank_n` high and all ones with `blank_n` low.
- R10: A change on `blank_n` reaches `drive_out` in the same cycle. A latch copy is sampled at the clock edge where `latch_en` is high, and it is visible right after that edge, not before it.
- R11: A `shift_clk` level held high for many cycles gives exactly one shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| shift_clk | input | 1 | Serial shift clock; it is synchronized, and each rising edge advances the chain |
| shift_din | input | 1 | Serial data, sampled with the shift clock |
| latch_en | input | 1 | High: copy the shift register into the selected latch every cycle |
| latch_sel | input | 1 | 1 selects the data latch, 0 selects the polarity latch |
| blank_n | input | 1 | 0 forces the outputs to the polarity pattern |
| cascade_out | output | 1 | Serial output to the next device in a chain |
| drive_out | output | CHANNELS | Parallel channel outputs |

## Verification
A shift advance and a latch copy can land in the same system cycle. When they do, the latch must take the contents from before the shift, and the new word arrives one cycle later. The bench holds `latch_en` high with the data latch selected while it shifts a byte bit by bit. After each shift it compares the outputs with the modelled register contents. A blank toggle that falls in a cycle with a pending latch copy is also judged: the blank effect is checked right away, and the copied word is checked after the edge.

// File: rtl/sdl_pkg.sv
package sdl_pkg;

   // Latch target encoding carried by the select input
   typedef enum logic {
      TGT_POLARITY = 1'b0,
      TGT_DATA     = 1'b1
   } latch_tgt_e;

   // Smallest synchronizer depth that is accepted
   localparam int unsigned SYNC_MIN = 2;

   // One channel of the output mixer: blank forces a one into the XNOR
   function automatic logic mix_bit(input logic blank_n, input logic data, input logic pol);
      logic sel_v;
      sel_v = blank_n ? data : 1'b1;
      return ~(sel_v ^ pol);
   endfunction

endpackage

// File: rtl/sdl_edge_sync.sv
module sdl_edge_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sclk_in,
   input  logic din_in,
   output logic rise,
   output logic din_s
);
   import sdl_pkg::*;

   localparam int unsigned LAST = STAGES - 1;

   if (STAGES < SYNC_MIN) begin : g_bad_stages
      $error("sdl_edge_sync: STAGES below minimum");
   end

   logic [STAGES-1:0] sclk_pipe;
   logic [STAGES-1:0] din_pipe;
   logic              sclk_prev;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sclk_pipe[s] <= 1'b0;
               din_pipe[s]  <= 1'b0;
            end else begin
               sclk_pipe[s] <= sclk_in;
               din_pipe[s]  <= din_in;
            end
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sclk_pipe[s] <= 1'b0;
               din_pipe[s]  <= 1'b0;
            end else begin
               sclk_pipe[s] <= sclk_pipe[s-1];
               din_pipe[s]  <= din_pipe[s-1];
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sclk_prev <= 1'b0;
      else        sclk_prev <= sclk_pipe[LAST];
   end

   assign rise  = sclk_pipe[LAST] & ~sclk_prev;
   assign din_s = din_pipe[LAST];

endmodule

// File: rtl/sdl_shift_chain.sv
module sdl_shift_chain #(
   parameter int unsigned WIDTH   = 8,
   parameter bit          RETIME  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv,
   input  logic             din,
   output logic [WIDTH-1:0] q,
   output logic             cascade
);
   localparam int unsigned TOP = WIDTH - 1;

   if (WIDTH < 2) begin : g_bad_width
      $error("sdl_shift_chain: WIDTH must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= '0;
      else if (adv) q <= {q[TOP-1:0], din};
   end

   if (RETIME) begin : g_retimed
      logic cas_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   cas_q <= 1'b0;
         else if (adv) cas_q <= q[TOP];
      end
      assign cascade = cas_q;
   end else begin : g_direct
      assign cascade = q[TOP];
   end

endmodule

// File: rtl/sdl_latch_bank.sv
module sdl_latch_bank #(
   parameter int unsigned WIDTH          = 8,
   parameter bit          POL_RESET_ONES = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  sdl_pkg::latch_tgt_e target,
   input  logic [WIDTH-1:0]  src,
   output logic [WIDTH-1:0]  data_q,
   output logic [WIDTH-1:0]  pol_q
);
   import sdl_pkg::*;

   localparam logic [WIDTH-1:0] POL_INIT = POL_RESET_ONES ? {WIDTH{1'b1}} : {WIDTH{1'b0}};

   logic load_data;
   logic load_pol;

   assign load_data = load && (target == TGT_DATA);
   assign load_pol  = load && (target == TGT_POLARITY);

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            data_q[i] <= 1'b0;
            pol_q[i]  <= POL_INIT[i];
         end else begin
            if (load_data) data_q[i] <= src[i];
            if (load_pol)  pol_q[i]  <= src[i];
         end
      end
   end

endmodule

// File: rtl/sdl_out_mix.sv
module sdl_out_mix #(
   parameter int unsigned WIDTH = 8
) (
   input  logic             blank_n,
   input  logic [WIDTH-1:0] data,
   input  logic [WIDTH-1:0] pol,
   output logic [WIDTH-1:0] out
);
   import sdl_pkg::*;

   for (genvar i = 0; i < WIDTH; i++) begin : g_ch
      assign out[i] = mix_bit(blank_n, data[i], pol[i]);
   end

endmodule

// File: rtl/sdl_driver.sv
module sdl_driver #(
   parameter int unsigned CHANNELS       = 8,
   parameter int unsigned SYNC_STAGES    = 2,
   parameter bit          CASCADE_RETIME = 1'b1,
   parameter bit          POL_RESET_ONES = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                shift_clk,
   input  logic                shift_din,
   input  logic                latch_en,
   input  logic                latch_sel,
   input  logic                blank_n,
   output logic                cascade_out,
   output logic [CHANNELS-1:0] drive_out
);
   import sdl_pkg::*;

   if (CHANNELS < 2) begin : g_bad_channels
      $error("sdl_driver: CHANNELS must be at least 2");
   end
   if (SYNC_STAGES < SYNC_MIN) begin : g_bad_sync
      $error("sdl_driver: SYNC_STAGES below minimum");
   end

   logic                shift_rise;
   logic                din_s;
   logic [CHANNELS-1:0] shift_q;
   logic [CHANNELS-1:0] data_q;
   logic [CHANNELS-1:0] pol_q;
   latch_tgt_e          target;

   assign target = latch_sel ? TGT_DATA : TGT_POLARITY;

   sdl_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .sclk_in (shift_clk),
      .din_in  (shift_din),
      .rise    (shift_rise),
      .din_s   (din_s)
   );

   sdl_shift_chain #(.WIDTH(CHANNELS), .RETIME(CASCADE_RETIME)) u_chain (
      .clk     (clk),
      .rst_n   (rst_n),
      .adv     (shift_rise),
      .din     (din_s),
      .q       (shift_q),
      .cascade (cascade_out)
   );

   sdl_latch_bank #(.WIDTH(CHANNELS), .POL_RESET_ONES(POL_RESET_ONES)) u_latch (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (latch_en),
      .target (target),
      .src    (shift_q),
      .data_q (data_q),
      .pol_q  (pol_q)
   );

   sdl_out_mix #(.WIDTH(CHANNELS)) u_mix (
      .blank_n (blank_n),
      .data    (data_q),
      .pol     (pol_q),
      .out     (drive_out)
   );

endmodule

// File: rtl/sdl_driver_chk.sv
module sdl_driver_chk #(
   parameter int unsigned CHANNELS       = 8,
   parameter bit          CASCADE_RETIME = 1'b1
) (
   input logic                clk,
   input logic                rst_n,
   input logic                latch_en,
   input logic                latch_sel,
   input logic                blank_n,
   input logic                shift_rise,
   input logic [CHANNELS-1:0] shift_q,
   input logic [CHANNELS-1:0] data_q,
   input logic [CHANNELS-1:0] pol_q,
   input logic [CHANNELS-1:0] drive_out,
   input logic                cascade_out
);
   localparam int unsigned TOP = CHANNELS - 1;

   // R1: on an advance, the upper stages take the old lower stages
   assert_shift_move_R1: assert property (@(posedge clk) disable iff (!rst_n)
      shift_rise |=> shift_q[TOP:1] == $past(shift_q[TOP-1:0]));

   // R3: without an advance the chain holds, whatever the latch controls do
   assert_shift_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !shift_rise |=> $stable(shift_q));

   // R11: an advance lasts one cycle even while the shift clock stays high
   assert_single_adv_R11: assert property (@(posedge clk) disable iff (!rst_n)
      shift_rise |=> !shift_rise);

   // R4: both latches hold while the enable is low
   assert_latch_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !latch_en |=> ($stable(data_q) && $stable(pol_q)));

   // R5: a data copy leaves polarity untouched and takes the shift contents
   assert_data_sel_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (latch_en && latch_sel) |=> ($stable(pol_q) && data_q == $past(shift_q)));

   // R6: a polarity copy leaves data untouched and takes the shift contents
   assert_pol_sel_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (latch_en && !latch_sel) |=> ($stable(data_q) && pol_q == $past(shift_q)));

   // R7: blanking shows the polarity pattern
   assert_blank_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !blank_n |-> drive_out == pol_q);

   // R2: the cascade stage trails the last shift stage by one advance
   if (CASCADE_RETIME) begin : g_cas_chk
      assert_cascade_R2: assert property (@(posedge clk) disable iff (!rst_n)
         shift_rise |=> cascade_out == $past(shift_q[TOP]));
   end

endmodule

bind sdl_driver sdl_driver_chk #(
   .CHANNELS       (CHANNELS),
   .CASCADE_RETIME (CASCADE_RETIME)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .latch_en    (latch_en),
   .latch_sel   (latch_sel),
   .blank_n     (blank_n),
   .shift_rise  (shift_rise),
   .shift_q     (shift_q),
   .data_q      (data_q),
   .pol_q       (pol_q),
   .drive_out   (drive_out),
   .cascade_out (cascade_out)
);

// File: tb/sdl_driver_test.sv
module sdl_driver_test;
   localparam int N = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic shift_clk = 1'b0;
   logic shift_din = 1'b0;
   logic latch_en = 1'b0;
   logic latch_sel = 1'b1;
   logic blank_n = 1'b1;
   logic cascade_out;
   logic [N-1:0] drive_out;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;
   logic [N:0]   model;      // bits N-1..0: shift stages, bit N: cascade
   logic [N-1:0] cur_data;
   logic [N-1:0] cur_pol;

   always #5 clk = ~clk;

   sdl_driver #(.CHANNELS(N)) uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .shift_clk   (shift_clk),
      .shift_din   (shift_din),
      .latch_en    (latch_en),
      .latch_sel   (latch_sel),
      .blank_n     (blank_n),
      .cascade_out (cascade_out),
      .drive_out   (drive_out)
   );

   task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
   endtask

   // One shift pulse; shift completes within three edges after the rise
   task automatic pulse(input logic b, input int hi, input bit noise);
      @(negedge clk);
      shift_din = b;
      shift_clk = 1'b0;
      repeat (3) @(negedge clk) begin
         if (noise) begin latch_sel = ~latch_sel; blank_n = ~blank_n; end
      end
      shift_clk = 1'b1;
      repeat (hi) @(negedge clk) begin
         if (noise) begin latch_sel = ~latch_sel; blank_n = ~blank_n; end
      end
      shift_clk = 1'b0;
      model = {model[N-1:0], b};
   endtask

   task automatic shift_byte(input logic [N-1:0] v, input int hi, input bit noise);
      for (int i = N - 1; i >= 0; i--) pulse(v[i], hi, noise);
   endtask

   task automatic load(input bit sel);
      @(negedge clk);
      latch_sel = sel;
      latch_en = 1'b1;
      @(negedge clk);
      latch_en = 1'b0;
      if (sel) cur_data = model[N-1:0];
      else     cur_pol  = model[N-1:0];
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      logic [N-1:0] pols [4];
      pols[0] = 8'hFF; pols[1] = 8'h00; pols[2] = 8'hA5; pols[3] = 8'h3C;
      model = '0;
      cur_data = '0;
      cur_pol = '1;

      // R9: reset state
      repeat (3) @(negedge clk);
      #1;
      chk("R9 outputs after reset, blank high", drive_out, 8'h00);
      blank_n = 1'b0;
      #1;
      chk("R9 outputs after reset, blank low", drive_out, 8'hFF);
      chk("R9 cascade after reset", {7'b0, cascade_out}, 8'h00);
      blank_n = 1'b1;
      @(negedge clk);
      rst_n = 1'b1;

      // R1 R2 R5 R6 R7 R8: sweep polarity patterns against every data byte
      foreach (pols[k]) begin
         shift_byte(pols[k], 4, 1'b0);
         load(1'b0);
         #1;
         chk("R6 data kept on polarity copy", drive_out, ~(cur_data ^ cur_pol));
         for (int d = 0; d < 256; d++) begin
            shift_byte(N'(d), 4, 1'b0);
            #1;
            chk("R2 cascade", {7'b0, cascade_out}, {7'b0, model[N]});
            load(1'b1);
            #1;
            chk("R8 R1 outputs blank high", drive_out, ~(N'(d) ^ pols[k]));
            blank_n = 1'b0;
            #1;
            chk("R7 R5 outputs blank low", drive_out, pols[k]);
            blank_n = 1'b1;
         end
      end

      // R2: the last first-in bit reaches the cascade one shift later
      shift_byte(8'h80, 4, 1'b0);
      pulse(1'b0, 4, 1'b0);
      #1;
      chk("R2 first bit at cascade after N+1 shifts", {7'b0, cascade_out}, 8'h01);

      // R4: shifting with enable low leaves the latches
      shift_byte(8'h5A, 4, 1'b0);
      #1;
      chk("R4 hold while enable low", drive_out, ~(cur_data ^ cur_pol));

      // R3: control toggling during shifts does not disturb the chain
      shift_byte(8'hC3, 4, 1'b1);
      latch_sel = 1'b1;
      blank_n = 1'b1;
      load(1'b1);
      #1;
      chk("R3 shift independent of controls", drive_out, ~(8'hC3 ^ cur_pol));

      // R11: long high shift-clock levels give one shift each
      shift_byte(8'h96, 20, 1'b0);
      load(1'b1);
      #1;
      chk("R11 one shift per rising edge", drive_out, ~(8'h96 ^ cur_pol));

      // R10: copy visible only after the sampling edge; blank immediate
      shift_byte(8'h0F, 4, 1'b0);
      @(negedge clk);
      latch_sel = 1'b1;
      latch_en = 1'b1;
      blank_n = 1'b0;
      #1;
      chk("R10 blank takes effect in same cycle", drive_out, cur_pol);
      blank_n = 1'b1;
      #1;
      chk("R10 copy not visible before edge", drive_out, ~(8'h96 ^ cur_pol));
      @(negedge clk);
      latch_en = 1'b0;
      cur_data = 8'h0F;
      #1;
      chk("R10 copy visible after edge", drive_out, ~(8'h0F ^ cur_pol));

      // R1 R5: enable held high during shifts follows the chain each shift
      @(negedge clk);
      latch_sel = 1'b1;
      latch_en = 1'b1;
      for (int i = N - 1; i >= 0; i--) begin
         pulse(8'hE4 >> i, 4, 1'b0);
         @(negedge clk);
         #1;
         chk("R1 R5 copy follows each shift", drive_out, ~(model[N-1:0] ^ cur_pol));
      end
      latch_en = 1'b0;

      done = 1'b1;
      summary();
      $finish;
   end

endmodule